// File: doc/BRIEF.md
# Low-Power Mode Command Sequencer

This block is a per-core power controller. It runs a short byte-coded program stored in a 64-byte sequence memory. Software loads the memory and a small set of registers through a plain register port. When the core signals wait-for-interrupt and the sequencer is armed, the sequencer starts the program at the byte index held in the control register.

The program drives four power-control outputs: clock gate, isolation clamp, memory retention and power collapse. It can insert delays. A wait command parks the sequencer until the wake interrupt arrives. The commands after the wait bring the core back up. An end command returns the sequencer to idle. Several low-power modes share one memory, and each mode is a separate program chosen only by its start index.

A status register shows the sequencer state, the program counter and a sticky error flag. The error flag is set when a program runs off the last memory byte.

Top module: `lpm_seq_top`

## Requirements
- R1: The configuration register (offset 0x08), the control register (0x30) and the delay register (0x34) each read back exactly the 32-bit value last written to them.
- R2: The sequence memory holds 64 bytes at offsets 0x80 to 0xBC as 16 words. Byte k of a word is bits 8k+7:8k and holds command index 4*word+k. Each word reads back as written.
- R3: If control bit 0 (enable) is set, a wait-for-interrupt assertion seen while idle starts execution at the index in control bits 10:4 (low 6 bits used).
- R4: A wait-for-interrupt seen while enable is clear leaves the sequencer idle and the outputs unchanged.
- R5: A command with bit 7 clear that is neither 0x00 nor 0x0F copies its bits 3:0 to the control outputs: bit 0 clock gate, bit 1 clamp, bit 2 retention, bit 3 power collapse. It takes one cycle.
- R6: Command 0x00 stalls the sequencer in the wait state, with the outputs held, until wake_irq_i is high at a clock edge. Execution then resumes at the next index.
- R7: A command with bit 7 set leaves the outputs unchanged and occupies the delay register's low 16 bits plus 2 clock cycles.
- R8: Command 0x0F returns the sequencer to idle. The outputs and the program counter keep their values.
- R9: A write to the start index while a program runs has no effect on that run. It is used only at the next trigger.
- R10: Status register 0x0C reports the state in bits 1:0 (0 idle, 1 running or delaying, 2 waiting for wake), the program counter in bits 13:8 and the error flag in bit 16.
- R11: A command other than 0x0F found at index 63 is not executed. Instead the sequencer returns to idle, drives all outputs to 0 and sets the error flag. The flag stays set until reset.
- R12: After reset all registers, the sequence memory and the outputs are 0, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| wfi_i | input | 1 | Core wait-for-interrupt indication |
| wake_irq_i | input | 1 | Wake interrupt |
| ctrl_o | output | 4 | Power controls: gate, clamp, retention, collapse |
| lpm_active_o | output | 1 | Sequencer not idle |

## Verification
A wrong program counter shows up at once in the status register. Within a cycle or two it also shows up on ctrl_o, because the wrong command bytes drive the outputs. A wrong delay count moves the cycle in which the outputs change after wake, and the bench measures that cycle exactly. A bad state transition shows as one of the following, each visible in status bits 1:0 a few cycles after the trigger:
- a run that starts while disabled,
- a run that never stops,
- a missing abort at index 63.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DELAY, ST_WAIT} seq_state_e;
  localparam logic [7:0] CMD_END  = 8'h0F;
  localparam logic [7:0] CMD_WAIT = 8'h00;
  localparam logic [1:0] STS_IDLE = 2'd0;
  localparam logic [1:0] STS_RUN  = 2'd1;
  localparam logic [1:0] STS_WAIT = 2'd2;
endpackage

// File: rtl/lpm_seq_regs.sv
module lpm_seq_regs #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEQ_DEPTH = 64,
  parameter int DLY_W     = 16,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        sts_state_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              err_i,
  output logic              en_o,
  output logic [PC_W-1:0]   start_idx_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic [7:0]        cmd_o
);
  localparam int WORDS = SEQ_DEPTH / 4;
  localparam int IDX_LSB = 4;
  localparam logic [ADDR_W-1:0] CFG_OFS  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] STS_OFS  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] CTL_OFS  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] DLY_OFS  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] SEQ_BASE = ADDR_W'(8'h80);

  logic [DATA_W-1:0] cfg_q, ctl_q, dly_q;
  logic [DATA_W-1:0] seq_words [WORDS];
  logic [ADDR_W-1:0] seq_off;
  logic              seq_hit;

  assign seq_off = addr_i - SEQ_BASE;
  assign seq_hit = (addr_i >= SEQ_BASE) && (seq_off < ADDR_W'(SEQ_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= '0;
      dly_q <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_OFS) cfg_q <= wdata_i;
      if (addr_i == CTL_OFS) ctl_q <= wdata_i;
      if (addr_i == DLY_OFS) dly_q <= wdata_i;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (we_i && seq_hit && seq_off[PC_W-1:2] == (PC_W-2)'(w)) word_q <= wdata_i;
    end
    assign seq_words[w] = word_q;
  end

  assign en_o        = ctl_q[0];
  assign start_idx_o = ctl_q[IDX_LSB +: PC_W];
  assign dly_o       = dly_q[DLY_W-1:0];
  assign cmd_o       = seq_words[pc_i[PC_W-1:2]][8*pc_i[1:0] +: 8];

  always_comb begin
    rdata_o = '0;
    if (seq_hit) rdata_o = seq_words[seq_off[PC_W-1:2]];
    else if (addr_i == CFG_OFS) rdata_o = cfg_q;
    else if (addr_i == CTL_OFS) rdata_o = ctl_q;
    else if (addr_i == DLY_OFS) rdata_o = dly_q;
    else if (addr_i == STS_OFS) begin
      rdata_o[1:0]          = sts_state_i;
      rdata_o[8 +: PC_W]    = pc_i;
      rdata_o[16]           = err_i;
    end
  end
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import lpm_seq_pkg::*;
#(
  parameter int SEQ_DEPTH = 64,
  parameter int DLY_W     = 16,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PC_W-1:0]  start_idx_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             wfi_i,
  input  logic             wake_i,
  input  logic [7:0]       cmd_i,
  output seq_state_e       state_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [3:0]       ctrl_o,
  output logic             err_o
);
  localparam logic [PC_W-1:0] LAST_IDX = PC_W'(SEQ_DEPTH - 1);

  seq_state_e       state_q;
  logic [PC_W-1:0]  pc_q;
  logic [DLY_W-1:0] cnt_q;
  logic [3:0]       ctrl_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wfi_i && en_i) begin
          pc_q    <= start_idx_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (cmd_i == CMD_END) begin
            state_q <= ST_IDLE;
          end else if (pc_q == LAST_IDX) begin
            // ran off the end: abort to run-mode outputs
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            err_q   <= 1'b1;
          end else begin
            pc_q <= pc_q + PC_W'(1);
            if (cmd_i == CMD_WAIT) state_q <= ST_WAIT;
            else if (cmd_i[7]) begin
              cnt_q   <= dly_i;
              state_q <= ST_DELAY;
            end else ctrl_q <= cmd_i[3:0];
          end
        end
        ST_DELAY: if (cnt_q == '0) state_q <= ST_EXEC;
                  else cnt_q <= cnt_q - DLY_W'(1);
        ST_WAIT: if (wake_i) state_q <= ST_EXEC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign pc_o    = pc_q;
  assign ctrl_o  = ctrl_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
  import lpm_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEQ_DEPTH = 64,
  parameter int DLY_W     = 16,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wfi_i,
  input  logic              wake_irq_i,
  output logic [3:0]        ctrl_o,
  output logic              lpm_active_o
);
  seq_state_e       state;
  logic [PC_W-1:0]  pc, start_idx;
  logic [DLY_W-1:0] dly;
  logic [7:0]       cmd;
  logic             en, err;
  logic [1:0]       sts_state;

  always_comb begin
    unique case (state)
      ST_IDLE: sts_state = STS_IDLE;
      ST_WAIT: sts_state = STS_WAIT;
      default: sts_state = STS_RUN;
    endcase
  end

  lpm_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_DEPTH(SEQ_DEPTH), .DLY_W(DLY_W)) i_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .rdata_o(reg_rdata_o),
    .sts_state_i(sts_state), .pc_i(pc), .err_i(err),
    .en_o(en), .start_idx_o(start_idx), .dly_o(dly), .cmd_o(cmd)
  );

  lpm_seq_fsm #(.SEQ_DEPTH(SEQ_DEPTH), .DLY_W(DLY_W)) i_fsm (
    .clk_i, .rst_ni,
    .en_i(en), .start_idx_i(start_idx), .dly_i(dly),
    .wfi_i, .wake_i(wake_irq_i), .cmd_i(cmd),
    .state_o(state), .pc_o(pc), .ctrl_o, .err_o(err)
  );

  assign lpm_active_o = (state != ST_IDLE);
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_seq_pkg::*;
#(
  parameter int SEQ_DEPTH = 64,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input seq_state_e      state,
  input logic [PC_W-1:0] pc,
  input logic [7:0]      cmd,
  input logic            en,
  input logic            err,
  input logic            wfi_i,
  input logic            wake_irq_i,
  input logic [3:0]      ctrl_o
);
  // R4
  no_start_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !(wfi_i && en)) |=> (state == ST_IDLE && $stable(ctrl_o)));
  // R6
  wait_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && !wake_irq_i) |=> (state == ST_WAIT && $stable(ctrl_o) && $stable(pc)));
  // R7
  delay_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DELAY) |=> $stable(ctrl_o));
  // R8
  end_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && cmd == CMD_END) |=> (state == ST_IDLE && $stable(ctrl_o) && $stable(pc)));
  // R11
  overrun_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && pc == PC_W'(SEQ_DEPTH - 1) && cmd != CMD_END)
      |=> (state == ST_IDLE && ctrl_o == 4'h0 && err));
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err |=> err);
endmodule

bind lpm_seq_top lpm_seq_chk #(.SEQ_DEPTH(SEQ_DEPTH)) i_chk (
  .clk_i, .rst_ni, .state(state), .pc(pc), .cmd(cmd), .en(en), .err(err),
  .wfi_i, .wake_irq_i, .ctrl_o
);

// File: tb/test_lpm_seq_top.sv
module test_lpm_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        wfi = 1'b0;
  logic        wake = 1'b0;
  logic [3:0]  ctrl;
  logic        active;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5ns clk = ~clk;

  lpm_seq_top i_lpm_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .wfi_i(wfi), .wake_irq_i(wake), .ctrl_o(ctrl), .lpm_active_o(active)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1ns; d = rdata;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi = 1'b1; @(negedge clk); wfi = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  function automatic logic [31:0] sts(logic [1:0] st, int pc, bit e);
    return {15'd0, e, 2'd0, 6'(pc), 6'd0, st};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h30, d); chk("R12 ctl", d, 0);
    rd(8'h0C, d); chk("R12 status", d, 0);
    rd(8'h84, d); chk("R12 seq word", d, 0);
    chk("R12 ctrl", ctrl, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h08, 32'hA5A5_1234); rd(8'h08, d); chk("R1 cfg", d, 32'hA5A5_1234);
    wr(8'h34, 32'h0000_0014); rd(8'h34, d); chk("R1 dly", d, 32'h14);
    wr(8'h30, 32'hDEAD_0000); rd(8'h30, d); chk("R1 ctl", d, 32'hDEAD_0000);
    wr(8'h30, 32'h0);
    // standby @0: 01 00 10 0F ; collapse @4: 03 07 1F 00 17 80 10 0F
    wr(8'h80, 32'h0F10_0001);
    wr(8'h84, 32'h001F_0703);
    wr(8'h88, 32'h0F10_8017);
    rd(8'h84, d); chk("R2 word1", d, 32'h001F_0703);
    rd(8'h88, d); chk("R2 word2", d, 32'h0F10_8017);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(8'h30, 32'h40);
    pulse_wfi();
    repeat (5) @(negedge clk);
    rd(8'h0C, d); chk("R4 status idle", d, sts(0, 0, 0));
    chk("R4 ctrl unchanged", ctrl, 0);
  endtask

  task automatic t_standby();
    logic [31:0] d;
    wr(8'h30, 32'h1);
    pulse_wfi();
    repeat (4) @(negedge clk);
    chk("R5 gate only", ctrl, 4'h1);
    rd(8'h0C, d); chk("R6 R10 waiting pc2", d, sts(2, 2, 0));
    repeat (5) @(negedge clk);
    chk("R6 held while waiting", ctrl, 4'h1);
    wr(8'h30, 32'h41); // R9: new index mid-run
    pulse_wake();
    repeat (4) @(negedge clk);
    chk("R5 cleared", ctrl, 4'h0);
    rd(8'h0C, d); chk("R8 R9 idle pc3", d, sts(0, 3, 0));
  endtask

  task automatic t_collapse();
    logic [31:0] d;
    int n;
    wr(8'h34, 32'd20);
    pulse_wfi();
    repeat (6) @(negedge clk);
    chk("R3 R9 start at 4", ctrl, 4'hF);
    rd(8'h0C, d); chk("R3 waiting pc8", d, sts(2, 8, 0));
    @(negedge clk); wake = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); n++;
      @(negedge clk); wake = 1'b0;
      if (n == 2) chk("R5 partial restore", ctrl, 4'h7);
      if (n == 10) chk("R7 delay holds outputs", ctrl, 4'h7);
      if (ctrl == 4'h0) break;
    end
    // wake edge + cmd 8 + delay (20+2) + cmd 10
    chk("R7 delay length", n, 20 + 5);
    repeat (2) @(negedge clk);
    rd(8'h0C, d); chk("R8 idle after end", d, sts(0, 11, 0));
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    wr(8'h8C, 32'h1F1F_1F1F);
    wr(8'hBC, 32'h0101_0101);
    wr(8'h30, 32'h3C1);
    pulse_wfi();
    repeat (8) @(negedge clk);
    chk("R11 outputs run", ctrl, 4'h0);
    rd(8'h0C, d); chk("R11 error idle", d, sts(0, 63, 1));
    wr(8'h30, 32'h1);
    pulse_wfi();
    repeat (4) @(negedge clk);
    rd(8'h0C, d); chk("R11 error sticky", d, sts(2, 2, 1));
    pulse_wake();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_standby();
    t_collapse();
    t_overrun();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule